// File: doc/BRIEF.md
# Three-Channel Ramp-Compare DAC Sequencer

This block is the digital half of a low-power ramp-type digital-to-analog converter that has three output channels. An analog ramp generator outside the block rises in step with the block's clock. One shared 12-bit counter tracks that ramp. Each channel holds its own 12-bit code and needs only a comparator of its own. When the shared count reaches a channel's code, that channel gets a one-clock sample strobe, and its external track-and-hold captures the ramp voltage at that instant. The result is an analog level proportional to the code.

A conversion begins when the start input is seen high while the block is idle. At that edge all three codes are captured, and the ramp-reset output pulses for one clock so the analog ramp restarts from its floor. The counter then walks all 4,096 values. It is converted to Gray code in a pipeline register. The captured codes are held in Gray form and compared against that registered value, so every strobe lines up exactly with its count. Once the final count has been compared, the done flag rises. It stays high until the next accepted start. At a 4.125 MHz clock one conversion lasts about 1 ms.

Top module: `ramp_dac_seq`

## Requirements
- R1: During and after a synchronous active-low reset, `ramp_rst_o`, all `sample_o` bits and `done_o` are low, and the block is idle.
- R2: When `start_i` is high at a rising edge while idle, the three codes are captured at that edge (call it edge 0). `ramp_rst_o` is high for exactly the one clock that follows edge 0.
- R3: Channel n takes its code from `code_i[n*12 +: 12]`. Its strobe `sample_o[n]` is high for exactly the one clock that follows edge c+2, where c is the captured code.
- R4: Every channel strobes exactly once per conversion, including for codes 0 and 4095.
- R5: Changes on `code_i` after edge 0 have no effect on the strobes of the conversion in progress. They are used only at the next accepted start.
- R6: `start_i` is ignored while a conversion is in progress, up to and including edge 4097.
- R7: `done_o` rises at edge 4097, in the same clock as the strobe for code 4095. It stays high until the next accepted start, which clears it at that edge.
- R8: Channels with equal codes strobe in the same clock, each independently of the others.
- R9: If `start_i` is held high across the end of a conversion, the next conversion is accepted at edge 4098, which is back to back with the previous one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counter clock; rising-edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Conversion request, sampled at each rising edge |
| code_i | input | 36 | Three 12-bit codes, channel n at bits n*12 +: 12 |
| ramp_rst_o | output | 1 | One-clock restart pulse for the analog ramp |
| sample_o | output | 3 | Per-channel track-and-hold capture strobes |
| done_o | output | 1 | Conversion complete, held until the next start |

## Verification
The first code set is {0, 4095, 1234}. It exercises both ends of the count range, and it tells an off-by-one in the pipeline alignment apart from a missed wrap at the last count. A second set is changed mid-conversion and bombarded with ignored start requests. This separates code capture at start from live comparison, and it separates correct busy gating from early re-arming. A third set uses equal codes {7, 7, 7} and is entered back to back with start held high, which shows whether the channels are independent and whether re-acceptance timing is correct. A last set {2047, 2048, 4094} sits on Gray-code transitions where many binary bits flip, which exposes any mistake in the Gray conversion of either the counter or the codes.

// File: rtl/ramp_dac_pkg.sv
// Package: shared constants and types for the ramp-compare DAC sequencer.
// Assumes: nothing beyond IEEE 1800-2017.
package ramp_dac_pkg;
    localparam int DEF_NUM_CH = 3;
    localparam int DEF_CODE_W = 12;

    typedef enum logic [0:0] {
        SEQ_IDLE = 1'b0,
        SEQ_RUN  = 1'b1
    } seq_state_t;
endpackage

// File: rtl/ramp_dac_ctrl.sv
// Module: conversion sequencer.
// Accepts a start request only while idle, issues the capture/load strobe and
// the one-clock ramp restart, and raises done once the counter pipeline
// reports that the final count has been compared.
// Assumes: last_i is a single-cycle pulse produced once per conversion.
module ramp_dac_ctrl
    import ramp_dac_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic last_i,
    output logic load_o,
    output logic ramp_rst_o,
    output logic done_o
);
    seq_state_t state_q;

    // Purpose: a start is accepted only when idle.
    always_comb load_o = start_i && (state_q == SEQ_IDLE);

    // Purpose: idle/run state; run lasts until the final compare is made.
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= SEQ_IDLE;
        else if (load_o)
            state_q <= SEQ_RUN;
        else if (last_i)
            state_q <= SEQ_IDLE;
    end

    // Purpose: ramp restart pulse, one clock after acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ramp_rst_o <= 1'b0;
        else
            ramp_rst_o <= load_o;
    end

    // Purpose: done level, set at the final compare, cleared by a new start.
    always_ff @(posedge clk) begin
        if (!rst_n)
            done_o <= 1'b0;
        else if (load_o)
            done_o <= 1'b0;
        else if (last_i)
            done_o <= 1'b1;
    end

    // R2: the ramp restart never lasts more than one clock.
    a_r2_ramp_single: assert property (@(posedge clk) disable iff (!rst_n)
        ramp_rst_o |=> !ramp_rst_o);

    // R7: a fresh conversion always starts with done cleared.
    a_r7_done_clear_on_restart: assert property (@(posedge clk) disable iff (!rst_n)
        ramp_rst_o |-> !done_o);

    // R7: done only rises after the pipeline flagged the final compare.
    a_r7_done_after_last: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_o) |-> $past(last_i));
endmodule

// File: rtl/ramp_dac_counter.sv
// Module: shared ramp counter with a Gray-code pipeline stage.
// A binary counter walks 0..2^CODE_W-1 once per conversion; the next stage
// registers its Gray image with a valid and a last-count marker.
// Assumes: load_i is only asserted while the counter is not running.
module ramp_dac_counter #(
    parameter int CODE_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    output logic [CODE_W-1:0] gray_o,
    output logic              gvalid_o,
    output logic              glast_o
);
    localparam logic [CODE_W-1:0] CNT_MAX = '1;

    logic [CODE_W-1:0] cnt_q;
    logic              run_q;
    logic              at_max;

    always_comb at_max = (cnt_q == CNT_MAX);

    // Purpose: binary ramp counter, restarted by load, stops after the top value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            run_q <= 1'b0;
        end else if (load_i) begin
            cnt_q <= '0;
            run_q <= 1'b1;
        end else if (run_q) begin
            cnt_q <= cnt_q + 1'b1;
            if (at_max)
                run_q <= 1'b0;
        end
    end

    // Purpose: pipeline stage holding the Gray form of the current count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gray_o   <= '0;
            gvalid_o <= 1'b0;
            glast_o  <= 1'b0;
        end else begin
            gray_o   <= cnt_q ^ (cnt_q >> 1);
            gvalid_o <= run_q;
            glast_o  <= run_q && at_max;
        end
    end

    // R3: consecutive valid Gray counts differ in exactly one bit.
    a_r3_gray_single_step: assert property (@(posedge clk) disable iff (!rst_n)
        (gvalid_o && $past(gvalid_o)) |-> ($countones(gray_o ^ $past(gray_o)) == 1));
endmodule

// File: rtl/ramp_dac_chan.sv
// Module: one output channel.
// Captures its code (converted to Gray) on load and emits a one-clock
// sample strobe when the pipelined Gray count equals the captured code.
// Assumes: the count is valid for exactly one pass of all values per load.
module ramp_dac_chan #(
    parameter int CODE_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [CODE_W-1:0] code_i,
    input  logic [CODE_W-1:0] gray_i,
    input  logic              gvalid_i,
    output logic              sample_o
);
    logic [CODE_W-1:0] code_g_q;

    // Purpose: hold the Gray image of the code captured at start.
    always_ff @(posedge clk) begin
        if (!rst_n)
            code_g_q <= '0;
        else if (load_i)
            code_g_q <= code_i ^ (code_i >> 1);
    end

    // Purpose: registered comparator driving the track-and-hold strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)
            sample_o <= 1'b0;
        else
            sample_o <= gvalid_i && (gray_i == code_g_q);
    end

    // R3: a strobe is one clock wide.
    a_r3_strobe_width: assert property (@(posedge clk) disable iff (!rst_n)
        sample_o |=> !sample_o);
endmodule

// File: rtl/ramp_dac_seq.sv
// Module: top of the three-channel ramp-compare DAC sequencer.
// One shared Gray counter serves all channels; each channel has only a code
// register and a comparator.
// Assumes: the analog ramp restarts on ramp_rst_o and then rises one step per clock.
module ramp_dac_seq
    import ramp_dac_pkg::*;
#(
    parameter int NUM_CH = DEF_NUM_CH,
    parameter int CODE_W = DEF_CODE_W
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start_i,
    input  logic [NUM_CH*CODE_W-1:0] code_i,
    output logic                     ramp_rst_o,
    output logic [NUM_CH-1:0]        sample_o,
    output logic                     done_o
);
    logic              load;
    logic [CODE_W-1:0] gray;
    logic              gvalid;
    logic              glast;

    ramp_dac_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .last_i     (glast),
        .load_o     (load),
        .ramp_rst_o (ramp_rst_o),
        .done_o     (done_o)
    );

    ramp_dac_counter #(.CODE_W(CODE_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_i   (load),
        .gray_o   (gray),
        .gvalid_o (gvalid),
        .glast_o  (glast)
    );

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
        ramp_dac_chan #(.CODE_W(CODE_W)) u_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .load_i   (load),
            .code_i   (code_i[ch*CODE_W +: CODE_W]),
            .gray_i   (gray),
            .gvalid_i (gvalid),
            .sample_o (sample_o[ch])
        );
    end
endmodule

// File: tb/ramp_dac_seq_bench.sv
`timescale 1ns/1ps
module ramp_dac_seq_bench;
    localparam int NCH = 3;
    localparam int CW  = 12;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic [NCH*CW-1:0] code = '0;
    logic              ramp_rst;
    logic [NCH-1:0]    sample;
    logic              done;

    int errors = 0;
    int checks = 0;
    int cycles = 0;
    bit chk_en = 1'b0;
    string stag = "R3";
    string rtag = "R2";

    // behavioural reference state
    bit       m_busy = 0;
    int       m_k = 0;
    int       m_code [NCH];
    bit       m_ramp = 0;
    bit [NCH-1:0] m_samp = '0;
    bit       m_done = 0;
    bit       m_done_prev = 0;
    int       obs [NCH];

    always #2 clk = ~clk;

    ramp_dac_seq u_ramp_dac_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start),
        .code_i     (code),
        .ramp_rst_o (ramp_rst),
        .sample_o   (sample),
        .done_o     (done)
    );

    // reference model: edge counting since acceptance
    always @(posedge clk) begin
        cycles++;
        if (!rst_n) begin
            m_busy = 0; m_k = 0; m_ramp = 0; m_samp = '0; m_done = 0;
        end else begin
            m_ramp = 0;
            m_samp = '0;
            if (m_busy) begin
                m_k++;
                for (int ch = 0; ch < NCH; ch++)
                    if (m_k == m_code[ch] + 2) m_samp[ch] = 1'b1;
                if (m_k == 4097) begin
                    m_busy = 0;
                    m_done = 1;
                end
            end else if (start) begin
                m_busy = 1;
                m_k = 0;
                for (int ch = 0; ch < NCH; ch++) m_code[ch] = int'(code[ch*CW +: CW]);
                m_ramp = 1;
                m_done = 0;
            end
        end
    end

    task automatic check(input string tag, input int act, input int exp_v);
        checks++;
        if (act != exp_v) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d at cycle %0d", tag, act, exp_v, cycles);
        end
    endtask

    // per-cycle comparison away from the active edge
    always @(negedge clk) begin
        if (chk_en) begin
            check(rtag, int'(ramp_rst), int'(m_ramp));
            check(stag, int'(sample), int'(m_samp));
            check("R7", int'(done), int'(m_done));
            if (m_ramp)
                for (int ch = 0; ch < NCH; ch++) obs[ch] = 0;
            for (int ch = 0; ch < NCH; ch++)
                if (sample[ch]) obs[ch]++;
            if (m_done && !m_done_prev)
                for (int ch = 0; ch < NCH; ch++) check("R4", obs[ch], 1);
            m_done_prev = m_done;
        end
    end

    task automatic set_codes(input int a, input int b, input int c);
        code = {12'(c), 12'(b), 12'(a)};
    endtask

    task automatic pulse_start();
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
    endtask

    task automatic wait_idle();
        while (m_busy) @(negedge clk);
    endtask

    // watchdog
    initial begin
        #(4 * 200000);
        errors++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        for (int ch = 0; ch < NCH; ch++) begin obs[ch] = 0; m_code[ch] = 0; end
        repeat (5) @(negedge clk);
        // R1: outputs low out of reset
        check("R1", int'(ramp_rst), 0);
        check("R1", int'(sample), 0);
        check("R1", int'(done), 0);
        rst_n = 1'b1;
        chk_en = 1'b1;
        repeat (3) @(negedge clk);

        // R3/R4: range ends and a middle code
        stag = "R3"; rtag = "R2";
        set_codes(0, 4095, 1234);
        pulse_start();
        wait_idle();
        repeat (4) @(negedge clk);

        // R5/R6: codes changed and starts issued mid-conversion
        set_codes(100, 3000, 4000);
        pulse_start();
        stag = "R5"; rtag = "R6";
        repeat (50) @(negedge clk);
        set_codes(5, 6, 7);
        start = 1'b1;
        repeat (10) @(negedge clk);
        start = 1'b0;
        while (m_k < 4090) @(negedge clk);
        // R9: start held across the end, back-to-back acceptance; R8 equal codes
        set_codes(7, 7, 7);
        start = 1'b1;
        while (!m_done) @(negedge clk);
        rtag = "R9";
        @(negedge clk);
        start = 1'b0;
        stag = "R8";
        wait_idle();
        repeat (4) @(negedge clk);

        // R3: Gray transition codes
        stag = "R3"; rtag = "R2";
        set_codes(2047, 2048, 4094);
        pulse_start();
        wait_idle();
        repeat (4) @(negedge clk);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule